// File: doc/BRIEF.md
# Serial-Controlled Eight-Channel Switch Driver Core

This block is the digital control core of an eight-channel low-side switch driver. A host writes one command byte per frame over a 4-wire SPI slave port (active-low select, clock, data in, data out). Each bit of the command switches one channel. During the same frame, the host reads back one fault bit per channel. The power stages, clamps and fault sensing sit outside the block. The block receives each channel's fault indications as input flags and drives eight channel-enable outputs.

All SPI pins are sampled by the block's system clock through synchronizers. The system clock must run several times faster than the serial clock. A command reaches the channel latch only when its frame held a whole, nonzero number of bytes. Any frame with a partial byte leaves the channels as they were.

Two channels also have an active-low direct-drive input, so a host can pulse-width modulate them without any serial traffic. Two reset inputs are ORed into one internal reset: an external active-low reset and an undervoltage reset. That reset clears the latch and holds every output off.

Top module: `spi_octal_driver`

## Requirements
- R1: While `rstN` or `uvRstN` is low, every bit of `chanEn` is 0, including the two direct-drive channels. After reset releases, all channels stay off until a valid frame is latched.
- R2: Data is shifted in on each falling `sclk` while `csN` is low, first bit first. With exactly 8 clocks, the rising `csN` latches the byte. The first bit controls channel 8 (`chanEn[7]`) and the last bit controls channel 1 (`chanEn[0]`).
- R3: With 16, 24 or any other nonzero multiple of 8 clocks, the last 8 bits shifted in are latched, in the same bit-to-channel order as R2.
- R4: With a clock count that is not a nonzero multiple of 8 (0, 7 or 9, for example), the rising `csN` leaves the latch unchanged.
- R5: Channels 3 to 8 (`chanEn[7:2]`) are on exactly when their latched bit is 1.
- R6: Channels 1 and 2 (`chanEn[1:0]`) are on when their latched bit is 1 or their `dirN` bit is low. They are off only when the bit is 0 and `dirN` is high. A high `dirN` is the off (unconnected, pulled-up) condition.
- R7: When `csN` falls, a status byte is loaded, with channel i's bit taken from `faultOn[i]` if the channel is on and from `faultOff[i]` if it is off. Channel 8's bit appears on `sdo` first, and each falling `sclk` presents the next bit.
- R8: `sdoOe` (the enable for the `sdo` pad driver) is 0 while `csN` is high and 1 while the device is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rstN | input | 1 | External reset, active low |
| uvRstN | input | 1 | Undervoltage reset, active low |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idle low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (status) |
| sdoOe | output | 1 | Output enable for the sdo pad (high impedance when 0) |
| dirN | input | NUM_DIRECT | Active-low direct-drive inputs for channels 1 and 2 |
| faultOn | input | NUM_CH | Per-channel fault flag valid while the channel is on |
| faultOff | input | NUM_CH | Per-channel fault flag valid while the channel is off |
| chanEn | output | NUM_CH | Channel enables, bit i drives channel i+1 |

## Verification
The bench covers frames of 0, 7, 8, 9, 16 and 24 clocks. A design that counted clocks modulo 8 without a nonzero check would latch on an empty frame, and one that accepted any count of 8 or more would latch on 9. Long frames must latch the final byte, not the first, so a design that stopped shifting after eight clocks shows the wrong channels. The status byte is checked with channels both on and off, which catches a swapped fault selection or reversed bit order. Resets are applied while a direct input is low, so a design that let the direct path bypass the reset gating would show a channel on during reset.

// File: rtl/octdrv_pkg.sv
package octdrv_pkg;
  typedef struct packed {
    logic loadStatus;
    logic shiftIn;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/octdrv_sync.sv
module octdrv_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
        stage[g] <= RESET_VAL;
      end else begin
        if (g == 0) stage[g] <= d;
        else        stage[g] <= stage[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/octdrv_ctrl.sv
module octdrv_ctrl
  import octdrv_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    csS,
  input  logic    sclkS,
  output strobe_t strb,
  output logic    selected
);
  localparam int CW = $clog2(NUM_CH);

  logic          csPrev, sclkPrev;
  logic [CW-1:0] bitCnt;
  logic          anyBits;
  logic          csFall, csRise, sclkFall;

  assign csFall   = csPrev & ~csS;
  assign csRise   = ~csPrev & csS;
  assign sclkFall = sclkPrev & ~sclkS;
  assign selected = ~csS & ~csPrev;

  always_comb begin
    strb.loadStatus = csFall;
    strb.shiftIn    = sclkFall & selected;
    strb.commit     = csRise & anyBits & (bitCnt == '0);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
      anyBits  <= 1'b0;
    end else begin
      csPrev   <= csS;
      sclkPrev <= sclkS;
      if (csFall) begin
        bitCnt  <= '0;
        anyBits <= 1'b0;
      end else if (strb.shiftIn) begin
        bitCnt  <= bitCnt + 1'b1;
        anyBits <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/octdrv_dp.sv
module octdrv_dp
  import octdrv_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NUM_DIRECT = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  strobe_t               strb,
  input  logic                  sdiS,
  input  logic [NUM_DIRECT-1:0] dirN,
  input  logic [NUM_CH-1:0]     faultOn,
  input  logic [NUM_CH-1:0]     faultOff,
  output logic [NUM_CH-1:0]     chanEn,
  output logic [NUM_CH-1:0]     latchQ,
  output logic                  sdo
);
  logic [NUM_CH-1:0] shiftQ;
  logic [NUM_CH-1:0] status;

  assign status = (chanEn & faultOn) | (~chanEn & faultOff);
  assign sdo    = shiftQ[NUM_CH-1];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shiftQ <= '0;
      latchQ <= '0;
    end else begin
      if (strb.loadStatus)   shiftQ <= status;
      else if (strb.shiftIn) shiftQ <= {shiftQ[NUM_CH-2:0], sdiS};
      if (strb.commit)       latchQ <= shiftQ;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    if (g < NUM_DIRECT) begin : g_direct
      assign chanEn[g] = ~rst & (latchQ[g] | ~dirN[(g < NUM_DIRECT) ? g : 0]);
    end else begin : g_serial
      assign chanEn[g] = ~rst & latchQ[g];
    end
  end
endmodule

// File: rtl/spi_octal_driver.sv
module spi_octal_driver
  import octdrv_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int NUM_DIRECT = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  uvRstN,
  input  logic                  csN,
  input  logic                  sclk,
  input  logic                  sdi,
  output logic                  sdo,
  output logic                  sdoOe,
  input  logic [NUM_DIRECT-1:0] dirN,
  input  logic [NUM_CH-1:0]     faultOn,
  input  logic [NUM_CH-1:0]     faultOff,
  output logic [NUM_CH-1:0]     chanEn
);
  logic              rst;
  logic              csS, sclkS, sdiS;
  strobe_t           strb;
  logic [NUM_CH-1:0] latchQ;

  assign rst = ~rstN | ~uvRstN;

  octdrv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({csN, sclk, sdi}), .q({csS, sclkS, sdiS})
  );

  octdrv_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .csS(csS), .sclkS(sclkS), .strb(strb), .selected(sdoOe)
  );

  octdrv_dp #(.NUM_CH(NUM_CH), .NUM_DIRECT(NUM_DIRECT)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .sdiS(sdiS), .dirN(dirN),
    .faultOn(faultOn), .faultOff(faultOff), .chanEn(chanEn), .latchQ(latchQ), .sdo(sdo)
  );
endmodule

// File: rtl/spi_octal_driver_chk.sv
module spi_octal_driver_chk #(
  parameter int NUM_CH = 8,
  parameter int NUM_DIRECT = 2
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  uvRstN,
  input logic                  csN,
  input logic                  sdoOe,
  input logic [NUM_DIRECT-1:0] dirN,
  input logic [NUM_CH-1:0]     chanEn,
  input logic [NUM_CH-1:0]     latchQ,
  input logic                  commit
);
  // R1: either reset input holds every channel off
  a_r1_reset_off: assert property (@(posedge clk)
    (!rstN || !uvRstN) |-> (chanEn == '0));

  // R6: a low direct input turns its channel on
  a_r6_direct_on: assert property (@(posedge clk) disable iff (!rstN || !uvRstN)
    ((~dirN & chanEn[NUM_DIRECT-1:0]) == ~dirN));

  // R4: the latch moves only after a commit strobe from the control
  a_r4_latch_on_commit: assert property (@(posedge clk) disable iff (!rstN || !uvRstN)
    !$stable(latchQ) |-> $past(commit));

  // R8: deselected long enough to clear the synchronizer means no drive on sdo
  a_r8_sdo_idle: assert property (@(posedge clk) disable iff (!rstN || !uvRstN)
    (csN && $past(csN) && $past(csN, 2)) |-> !sdoOe);
endmodule

bind spi_octal_driver spi_octal_driver_chk #(.NUM_CH(NUM_CH), .NUM_DIRECT(NUM_DIRECT)) u_chk (
  .clk(clk), .rstN(rstN), .uvRstN(uvRstN), .csN(csN), .sdoOe(sdoOe),
  .dirN(dirN), .chanEn(chanEn), .latchQ(latchQ), .commit(strb.commit)
);

// File: tb/spi_octal_driver_bench.sv
module spi_octal_driver_bench;
  logic clk = 1'b0;
  logic rstN, uvRstN, csN, sclk, sdi, sdo, sdoOe;
  logic [1:0] dirN;
  logic [7:0] faultOn, faultOff, chanEn;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_octal_driver u_spi_octal_driver (
    .clk(clk), .rstN(rstN), .uvRstN(uvRstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdoOe(sdoOe), .dirN(dirN), .faultOn(faultOn), .faultOff(faultOff),
    .chanEn(chanEn)
  );

  localparam int NV = 8;
  localparam int VN [NV] = '{8, 8, 16, 7, 9, 0, 24, 8};
  localparam logic [23:0] VD [NV] = '{24'h0000A5, 24'h00003C, 24'h0012F0, 24'h000055,
                                      24'h0001AA, 24'h000000, 24'h00FF81, 24'h000000};
  localparam logic [1:0] VDIR [NV] = '{2'b11, 2'b10, 2'b01, 2'b11, 2'b11, 2'b00, 2'b11, 2'b11};

  logic [7:0] modelLatch, first8;

  function automatic logic [7:0] expEn(input logic [7:0] lat, input logic [1:0] dn);
    return {lat[7:2], lat[1:0] | ~dn};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input logic [23:0] data);
    first8 = '0;
    csN = 1'b0;
    waitClk(6);
    check("R8 sdoOe selected", {7'd0, sdoOe}, 8'h01);
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i];
      waitClk(3);
      if (i < 8) first8 = {first8[6:0], sdo};
      sclk = 1'b1;
      waitClk(4);
      sclk = 1'b0;
      waitClk(5);
    end
    csN = 1'b1;
    waitClk(6);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; uvRstN = 1'b1; csN = 1'b1; sclk = 1'b0; sdi = 1'b0;
    dirN = 2'b00; faultOn = 8'h00; faultOff = 8'h00;
    waitClk(4);
    check("R1 reset with direct inputs low", chanEn, 8'h00);
    check("R8 sdoOe deselected", {7'd0, sdoOe}, 8'h00);
    dirN = 2'b11;
    rstN = 1'b1;
    waitClk(4);
    check("R1 off after release", chanEn, 8'h00);
    modelLatch = 8'h00;

    for (int v = 0; v < NV; v++) begin
      logic [7:0] expStat, en;
      string tag;
      dirN = VDIR[v];
      faultOn  = 8'hC3 ^ 8'(v * 17);
      faultOff = 8'h5A ^ 8'(v * 29);
      waitClk(2);
      en = expEn(modelLatch, dirN);
      expStat = (en & faultOn) | (~en & faultOff);
      frame(VN[v], VD[v]);
      if (VN[v] > 0 && VN[v] % 8 == 0) modelLatch = VD[v][7:0];
      if (VN[v] == 8) tag = "R2";
      else if (VN[v] > 0 && VN[v] % 8 == 0) tag = "R3";
      else tag = "R4";
      en = expEn(modelLatch, dirN);
      check({tag, " R5 channels 3-8"}, {chanEn[7:2], 2'b00}, {en[7:2], 2'b00});
      check({tag, " R6 channels 1-2"}, {6'd0, chanEn[1:0]}, {6'd0, en[1:0]});
      if (VN[v] >= 8) check("R7 status byte", first8, expStat);
      check("R8 sdoOe after frame", {7'd0, sdoOe}, 8'h00);
    end

    // R6: direct input pulses channel 1 with latched bit 0
    modelLatch = 8'h00;
    frame(8, 24'h000000);
    dirN = 2'b10;
    waitClk(1);
    check("R6 direct on", chanEn, 8'h01);
    dirN = 2'b11;
    waitClk(1);
    check("R6 direct off", chanEn, 8'h00);

    // R1: undervoltage reset clears a latched byte, direct low included
    frame(8, 24'h0000F7);
    check("R2 latch before undervoltage", chanEn, 8'hF7);
    dirN = 2'b00;
    uvRstN = 1'b0;
    waitClk(3);
    check("R1 undervoltage holds off", chanEn, 8'h00);
    dirN = 2'b11;
    uvRstN = 1'b1;
    waitClk(4);
    check("R1 latch cleared after undervoltage", chanEn, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule